// File: doc/BRIEF.md
# Scatter Segment to Descriptor Table Splitter

The block accepts a list of physical memory segments, each a 32-bit start address and a 32-bit byte length, and writes the matching bus-master descriptor table. Each table entry is a pair of 32-bit words. The even word holds the address, and the odd word holds the byte count and flags. Entries go out one word per cycle on a write port into the table memory. No entry crosses a 64 KB address boundary. An entry that would cover a full 64 KB is emitted as two 32 KB entries. The final entry carries an end marker.

A second count format is selected by `alt_fmt` for controllers that move 32-bit words. In that format the count is carried in the upper half-word and no end marker is written. When a table would need more entries than the memory holds, the block gives up and reports failure, so that the host can fall back to programmed I/O. It also reports failure when the segment list produced no entries at all.

The controller is one state machine:
- `ST_WAIT` accepts a segment and moves to `ST_ADDR`.
- `ST_ADDR` writes an address word and moves to `ST_CNT`. It can instead:
  - return to `ST_WAIT` when the segment is used up;
  - go to `ST_FIX` when a trailing zero-length last segment needs the marker patched;
  - go to `ST_DRAIN` on overflow before the last segment;
  - go to `ST_END`.
- `ST_CNT` writes the count word and returns to `ST_ADDR`, or goes to `ST_END` after the final entry.
- `ST_FIX` rewrites the previous count word with the marker and goes to `ST_END`.
- `ST_DRAIN` discards segments up to the last one, then goes to `ST_END`.
- `ST_END` pulses `done` and returns to `ST_WAIT`.

Top module: `prd_splitter`

## Requirements
- R1: After reset `seg_ready` is 1, while `tbl_we`, `done` and `fail` are 0 and `entry_count` is 0.
- R2: Each chunk is the smaller of the remaining length and 0x10000 minus address bits [15:0]. Entry k is written with its address at word 2k and its count word at word 2k+1. In normal format, count bits [15:0] hold the chunk length and bits [30:16] are zero.
- R3: A chunk of exactly 0x10000 bytes becomes two entries, each with count 0x8000. The first is at the chunk address and the second at that address plus 0x8000.
- R4: In normal format, bit 31 of the count word of the final entry is 1, and it is 0 on every other entry.
- R5: With `alt_fmt`=1 the count word is ((len>>2)-1)<<16, with bits [15:0] zero and bit 31 never set.
- R6: A table needing more than TABLE_DEPTH entries ends with `fail`=1 and `entry_count`=0. Exactly TABLE_DEPTH entries succeed.
- R7: A segment list that yields no entries (every length zero) ends with `fail`=1 and `entry_count`=0.
- R8: A zero-length segment writes no entry. If the last segment is zero-length, in normal format the previous count word is rewritten with bit 31 set.
- R9: After an overflow, the segments up to and including the one with `seg_last` are accepted without writes. The next table starts at word 0.
- R10: `done` is a one-cycle pulse after the final write. `fail` and `entry_count` are valid with it and hold until the next `done`.
- R11: A segment is taken only when `seg_valid` and `seg_ready` are both 1. `seg_ready` is 0 in every cycle with a table write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| alt_fmt | input | 1 | word-count format, held for a whole table |
| seg_valid | input | 1 | segment offered |
| seg_ready | output | 1 | segment accepted this cycle if valid |
| seg_addr | input | 32 | segment start address |
| seg_len | input | 32 | segment length in bytes |
| seg_last | input | 1 | last segment of the table |
| tbl_we | output | 1 | table word write strobe |
| tbl_addr | output | IDX_W | table word index |
| tbl_wdata | output | 32 | table word data |
| done | output | 1 | table finished pulse |
| fail | output | 1 | table failed, use programmed I/O |
| entry_count | output | CNT_W | entries in the finished table |

## Verification
The bench drives segments that start a few bytes below a 64 KB line, and checks that a design without the boundary rule would not write a single entry spanning the line. Aligned 64 KB segments catch a design that writes a zero count instead of two halves. Tables of exactly TABLE_DEPTH entries and one entry more expose an off-by-one in the capacity test, which would either reject a legal table or write past the memory. A trailing zero-length last segment and an all-empty list target a missing end marker and a falsely successful empty table, while an overflow followed by a fresh table shows whether the draining logic leaves the machine out of step with the segment stream.

// File: rtl/prd_pkg.sv
package prd_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_ADDR,
        ST_CNT,
        ST_FIX,
        ST_DRAIN,
        ST_END
    } prd_state_e;

    localparam logic [16:0] SPAN_64K  = 17'h10000;
    localparam logic [16:0] SPAN_32K  = 17'h08000;
    localparam logic [31:0] END_MARK  = 32'h8000_0000;

endpackage

// File: rtl/prd_chunk.sv
module prd_chunk
    import prd_pkg::*;
(
    input  logic [31:0] cur_addr,
    input  logic [31:0] remain,
    output logic [16:0] piece
);
    logic [16:0] room;
    logic [16:0] span;

    always_comb begin
        room  = SPAN_64K - {1'b0, cur_addr[15:0]};
        span  = (remain < 32'(room)) ? remain[16:0] : room;
        piece = (span == SPAN_64K) ? SPAN_32K : span;
    end
endmodule

// File: rtl/prd_cntword.sv
module prd_cntword (
    input  logic [16:0] piece,
    input  logic        alt_fmt,
    input  logic        is_final,
    output logic [31:0] word
);
    logic [15:0] words_m1;

    always_comb begin
        words_m1 = {2'b00, piece[15:2]} - 16'd1;
        if (alt_fmt)
            word = {words_m1, 16'h0000};
        else
            word = {is_final, 15'h0000, piece[15:0]};
    end
endmodule

// File: rtl/prd_splitter.sv
module prd_splitter
    import prd_pkg::*;
#(
    parameter int TABLE_DEPTH = 256,
    localparam int IDX_W = $clog2(2 * TABLE_DEPTH),
    localparam int CNT_W = $clog2(TABLE_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt_fmt,
    input  logic             seg_valid,
    output logic             seg_ready,
    input  logic [31:0]      seg_addr,
    input  logic [31:0]      seg_len,
    input  logic             seg_last,
    output logic             tbl_we,
    output logic [IDX_W-1:0] tbl_addr,
    output logic [31:0]      tbl_wdata,
    output logic             done,
    output logic             fail,
    output logic [CNT_W-1:0] entry_count
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(TABLE_DEPTH);

    prd_state_e       state, state_nx;
    logic [31:0]      cur_addr, remain, tail_word;
    logic             last_q;
    logic [16:0]      piece, piece_q;
    logic [CNT_W-1:0] cnt;
    logic [31:0]      cnt_word;
    logic             is_final, rem_zero, full;
    logic             end_ok, end_fail;

    prd_chunk u_chunk (
        .cur_addr (cur_addr),
        .remain   (remain),
        .piece    (piece)
    );

    prd_cntword u_word (
        .piece    (piece_q),
        .alt_fmt  (alt_fmt),
        .is_final (is_final),
        .word     (cnt_word)
    );

    assign rem_zero = (remain == 32'd0);
    assign full     = (cnt == CAP);
    assign is_final = last_q && (remain == 32'(piece_q));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        end_ok   = 1'b0;
        end_fail = 1'b0;
        unique case (state)
            ST_WAIT:  if (seg_valid) state_nx = ST_ADDR;
            ST_ADDR: begin
                if (rem_zero) begin
                    if (!last_q)              state_nx = ST_WAIT;
                    else if (cnt == '0)       begin state_nx = ST_END; end_fail = 1'b1; end
                    else if (alt_fmt)         begin state_nx = ST_END; end_ok = 1'b1; end
                    else                      state_nx = ST_FIX;
                end else if (full) begin
                    end_fail = last_q;
                    state_nx = last_q ? ST_END : ST_DRAIN;
                end else begin
                    state_nx = ST_CNT;
                end
            end
            ST_CNT: begin
                if (is_final) begin state_nx = ST_END; end_ok = 1'b1; end
                else          state_nx = ST_ADDR;
            end
            ST_FIX:   begin state_nx = ST_END; end_ok = 1'b1; end
            ST_DRAIN: if (seg_valid && seg_last) begin state_nx = ST_END; end_fail = 1'b1; end
            ST_END:   state_nx = ST_WAIT;
            default:  state_nx = ST_WAIT;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr    <= '0;
            remain      <= '0;
            last_q      <= 1'b0;
            piece_q     <= '0;
            cnt         <= '0;
            tail_word   <= '0;
            fail        <= 1'b0;
            entry_count <= '0;
        end else begin
            if (state == ST_WAIT && seg_valid) begin
                cur_addr <= seg_addr;
                remain   <= seg_len;
                last_q   <= seg_last;
            end
            if (state == ST_ADDR && !rem_zero && !full)
                piece_q <= piece;
            if (state == ST_CNT) begin
                cnt       <= cnt + 1'b1;
                cur_addr  <= cur_addr + 32'(piece_q);
                remain    <= remain - 32'(piece_q);
                tail_word <= cnt_word;
            end
            if (end_ok) begin
                fail        <= 1'b0;
                entry_count <= (state == ST_CNT) ? cnt + 1'b1 : cnt;
            end
            if (end_fail) begin
                fail        <= 1'b1;
                entry_count <= '0;
            end
            if (state == ST_END)
                cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        seg_ready = 1'b0;
        tbl_we    = 1'b0;
        tbl_addr  = '0;
        tbl_wdata = '0;
        done      = 1'b0;
        unique case (state)
            ST_WAIT, ST_DRAIN: seg_ready = 1'b1;
            ST_ADDR: begin
                tbl_we    = !rem_zero && !full;
                tbl_addr  = IDX_W'(cnt) << 1;
                tbl_wdata = cur_addr;
            end
            ST_CNT: begin
                tbl_we    = 1'b1;
                tbl_addr  = (IDX_W'(cnt) << 1) | IDX_W'(1);
                tbl_wdata = cnt_word;
            end
            ST_FIX: begin
                tbl_we    = 1'b1;
                tbl_addr  = (IDX_W'(cnt - 1'b1) << 1) | IDX_W'(1);
                tbl_wdata = tail_word | END_MARK;
            end
            ST_END:  done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/prd_splitter_chk.sv
module prd_splitter_chk #(
    parameter int IDX_W = 9,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alt_fmt,
    input logic             seg_ready,
    input logic             tbl_we,
    input logic [IDX_W-1:0] tbl_addr,
    input logic [31:0]      tbl_wdata,
    input logic             done,
    input logic             fail,
    input logic [CNT_W-1:0] entry_count
);
    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> !seg_ready);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    fail_zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (entry_count == '0));

    // R2
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && !tbl_addr[0]) |=> (tbl_we && tbl_addr == IDX_W'($past(tbl_addr) + 1'b1)));

    // R2
    norm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && tbl_addr[0] && !alt_fmt) |-> (tbl_wdata[15:0] != 16'h0 && tbl_wdata[30:16] == 15'h0));

    // R5
    alt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && tbl_addr[0] && alt_fmt) |-> (tbl_wdata[15:0] == 16'h0 && !tbl_wdata[31]));
endmodule

bind prd_splitter prd_splitter_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alt_fmt     (alt_fmt),
    .seg_ready   (seg_ready),
    .tbl_we      (tbl_we),
    .tbl_addr    (tbl_addr),
    .tbl_wdata   (tbl_wdata),
    .done        (done),
    .fail        (fail),
    .entry_count (entry_count)
);

// File: tb/tb_prd_splitter.sv
module tb_prd_splitter;
    localparam int DEPTH = 256;
    localparam int IDX_W = $clog2(2 * DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alt_fmt = 1'b0;
    logic seg_valid = 1'b0;
    logic seg_ready;
    logic [31:0] seg_addr = '0;
    logic [31:0] seg_len = '0;
    logic seg_last = 1'b0;
    logic tbl_we;
    logic [IDX_W-1:0] tbl_addr;
    logic [31:0] tbl_wdata;
    logic done, fail;
    logic [CNT_W-1:0] entry_count;

    always #5 clk = ~clk;

    prd_splitter #(.TABLE_DEPTH(DEPTH)) dut (.*);

    int checks = 0;
    int errors = 0;

    // monitor
    logic [31:0] got_mem [2*DEPTH];
    int          got_tag [2*DEPTH];
    int          cur_tag = 0;
    int          wr_total = 0;
    int          done_total = 0;
    logic        got_fail;
    int          got_cnt;

    always @(negedge clk) begin
        if (tbl_we) begin
            got_mem[tbl_addr] = tbl_wdata;
            got_tag[tbl_addr] = cur_tag;
            wr_total = wr_total + 1;
        end
        if (done) begin
            got_fail = fail;
            got_cnt = int'(entry_count);
            done_total = done_total + 1;
        end
    end

    // stimulus description and model
    logic [31:0] sa [8];
    logic [31:0] sl [8];
    int          ns;
    logic        use_alt;
    logic [31:0] exp_mem [2*DEPTH];
    int          exp_cnt, exp_writes;
    logic        exp_fail;

    task automatic check(input string tag, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input longint len, input logic alt);
        if (alt) return 32'(((len >> 2) - 1) << 16);
        return 32'(len & 64'hFFFF);
    endfunction

    task automatic model();
        int n = 0;
        logic ovf = 1'b0;
        for (int i = 0; i < ns; i++) begin
            longint a = longint'(sa[i]);
            longint r = longint'(sl[i]);
            while (r != 0 && !ovf) begin
                longint b = 64'h10000 - (a & 64'hFFFF);
                if (b > r) b = r;
                for (int h = 0; h < (((b & 64'hFFFF) == 0) ? 2 : 1); h++) begin
                    longint pl = ((b & 64'hFFFF) == 0) ? 64'h8000 : b;
                    if (n >= DEPTH) ovf = 1'b1;
                    else begin
                        exp_mem[2*n] = 32'(a + h * 64'h8000);
                        exp_mem[2*n+1] = enc(pl, use_alt);
                        n++;
                    end
                end
                a = a + b;
                r = r - b;
            end
        end
        exp_writes = 2 * n;
        if (ovf || n == 0) begin
            exp_fail = 1'b1;
            exp_cnt = 0;
        end else begin
            exp_fail = 1'b0;
            exp_cnt = n;
            if (!use_alt) begin
                exp_mem[2*n-1] = exp_mem[2*n-1] | 32'h8000_0000;
                if (sl[ns-1] == 0) exp_writes++;
            end
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] l, input logic last);
        seg_addr = a;
        seg_len = l;
        seg_last = last;
        seg_valid = 1'b1;
        while (!seg_ready) @(negedge clk);
        @(negedge clk);
        seg_valid = 1'b0;
    endtask

    task automatic run_table(input string tag);
        int d0 = done_total;
        int w0 = wr_total;
        cur_tag++;
        alt_fmt = use_alt;
        for (int i = 0; i < ns; i++) send(sa[i], sl[i], i == ns - 1);
        while (done_total == d0) @(negedge clk);
        @(negedge clk);
        model();
        check({tag, " fail"}, got_fail == exp_fail, got_fail, exp_fail);
        check({tag, " count"}, got_cnt == exp_cnt, got_cnt, exp_cnt);
        check({tag, " writes"}, (wr_total - w0) == exp_writes, wr_total - w0, exp_writes);
        if (!exp_fail) begin
            int bad = -1;
            for (int k = 0; k < 2 * exp_cnt; k++)
                if (bad < 0 && (got_tag[k] != cur_tag || got_mem[k] != exp_mem[k])) bad = k;
            check({tag, " table"}, bad < 0, (bad < 0) ? 0 : got_mem[bad], (bad < 0) ? 0 : exp_mem[bad]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 2 * DEPTH; k++) got_tag[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 reset ready", seg_ready === 1'b1, seg_ready, 1);
        check("R1 reset idle", {tbl_we, done, fail} === 3'b000, {tbl_we, done, fail}, 0);
        check("R1 reset count", entry_count === '0, entry_count, 0);

        // R2 R4 single entry
        use_alt = 0; ns = 1; sa[0] = 32'h0000_1000; sl[0] = 32'h200;
        run_table("R2 R4 single");
        check("R4 end mark literal", got_mem[1] == 32'h8000_0200, got_mem[1], 32'h8000_0200);

        // R2 boundary crossing
        ns = 1; sa[0] = 32'h0001_FF00; sl[0] = 32'h300;
        run_table("R2 cross");
        check("R2 first piece", got_mem[1] == 32'h0000_0100, got_mem[1], 32'h100);

        // R3 full 64K
        ns = 1; sa[0] = 32'h0004_0000; sl[0] = 32'h10000;
        run_table("R3 full64k");
        check("R3 second addr", got_mem[2] == 32'h0004_8000, got_mem[2], 32'h0004_8000);
        check("R3 last word", got_mem[3] == 32'h8000_8000, got_mem[3], 32'h8000_8000);

        // R5 alt format
        use_alt = 1; ns = 1; sa[0] = 32'h0000_2000; sl[0] = 32'h1000;
        run_table("R5 alt");
        check("R5 alt word", got_mem[1] == 32'h03FF_0000, got_mem[1], 32'h03FF_0000);

        // R7 empty
        use_alt = 0; ns = 2; sa[0] = 32'h100; sl[0] = 0; sa[1] = 32'h200; sl[1] = 0;
        run_table("R7 empty");

        // R8 trailing zero-length last
        ns = 3; sa[0] = 32'h0000_3000; sl[0] = 32'h40; sa[1] = 32'h0; sl[1] = 0;
        sa[2] = 32'h0000_5000; sl[2] = 0;
        run_table("R8 trailing zero");
        check("R8 patched mark", got_mem[1] == 32'h8000_0040, got_mem[1], 32'h8000_0040);

        // R6 exactly capacity, then one more
        ns = 1; sa[0] = 32'h0100_0000; sl[0] = 32'h10000 * 128;
        run_table("R6 exact capacity");
        sl[0] = 32'h10000 * 128 + 32'h10;
        run_table("R6 overflow");

        // R9 overflow before last, then fresh table
        ns = 3; sa[0] = 32'h0; sl[0] = 32'h10000 * 130; sa[1] = 32'h0020_0000; sl[1] = 32'h80;
        sa[2] = 32'h0030_0000; sl[2] = 32'h80;
        run_table("R9 drain");
        ns = 1; sa[0] = 32'h0000_0800; sl[0] = 32'h100;
        run_table("R9 resync");
        check("R9 restart at zero", got_tag[0] == cur_tag, got_tag[0], cur_tag);

        // R10 results held
        repeat (5) @(negedge clk);
        check("R10 held count", entry_count == CNT_W'(1) && !fail, entry_count, 1);

        // random tables
        for (int t = 0; t < 40; t++) begin
            use_alt = $urandom_range(0, 1);
            ns = $urandom_range(1, 4);
            for (int i = 0; i < ns; i++) begin
                sa[i] = $urandom & (use_alt ? 32'h00FF_FFFC : 32'h00FF_FFFE);
                sl[i] = $urandom_range(1, 32'h30000);
                if ($urandom_range(0, 5) == 0) sa[i] = sa[i] & 32'hFFFF_0000;
                if (use_alt) sl[i] = (sl[i] & ~32'h3) | 32'h4;
                if (i == ns - 1 && $urandom_range(0, 3) == 0) sl[i] = 0;
            end
            run_table("R2 R3 R4 R5 R8 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule